// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host end of a three-wire link to a 12-bit serial converter. When a read is requested, it pulls chip select low and waits a programmable setup time. It then toggles a serial clock that is derived from the system clock, and shifts in the converter's output line. After the last clock it raises chip select and presents the 12-bit result together with a one-cycle valid strobe. Chip select is then held high for a minimum interval before another conversion can begin.

Two framings can be chosen per read with `mode_i`:

- **Byte framing** sends sixteen clocks. The line is sampled on rising edges. The padded frame holds three leading zeros, twelve data bits MSB first, and one trailing zero.
- **Short framing** sends fifteen clocks. The line is sampled on falling edges. The frame holds two leading zeros and twelve data bits, with the final sample discarded.

After reset, a hold-off counter keeps the link idle while the converter's reference settles. Requests that arrive while the reader is busy, or still held off, are remembered and served later.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted, `cs_no` is 1, `sclk_o` is 0, `valid_o` is 0 and `result_o` is zero.
- R2: After reset is released, `cs_no` falls no earlier than POWERUP_CYC+1 cycles later. A start request made during that wait is served once the wait is over: with start seen on the first edge, `cs_no` falls exactly on edge POWERUP_CYC+1.
- R3: `sclk_o` is 0 whenever `cs_no` is 1. `cs_no` falls while `sclk_o` is low. Exactly SETUP_CYC cycles pass from the fall of `cs_no` to the first rise of `sclk_o`.
- R4: Inside a frame, every high phase of `sclk_o` lasts exactly HALF_DIV cycles. Every low phase after the first rise also lasts HALF_DIV cycles, and this includes the last low phase before `cs_no` rises.
- R5: With `mode_i`=0 (byte framing), the frame has 16 rising edges of `sclk_o`. `miso_i` is sampled just before each rising edge. Samples 4 to 15 form the result, MSB first.
- R6: With `mode_i`=1 (short framing), the frame has 15 rising edges. `miso_i` is sampled just before each falling edge. Samples 3 to 14 form the result, MSB first.
- R7: `cs_no` stays high for at least CS_HOLD_HALVES*HALF_DIV cycles between frames. When a frame follows back to back, the high time is exactly that interval plus one cycle.
- R8: `valid_o` is a single-cycle pulse in the cycle where `cs_no` rises. `result_o` changes only in that cycle.
- R9: A start request made during a frame is held, and one further frame runs after the hold-off with no new request. Several requests made during one frame merge into a single further frame.
- R10: `mode_i` is captured when `cs_no` falls. A change of `mode_i` during a frame does not change that frame's clock count or its result.
- R11: When the reader is idle, a start request seen on one clock edge makes `cs_no` fall on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read request, sampled each cycle |
| mode_i | input | 1 | Framing select: 0 byte (16 clocks), 1 short (15 clocks) |
| miso_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| result_o | output | DATA_W | Last converted value |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench sweeps converter codes in steps of seven, plus all walking-one codes, through both framings.

- **Framing:** a reader that takes data from the wrong window would return results shifted by one bit, or lose the MSB.
- **Mode capture:** a reader that latches the mode too late would change its clock count when `mode_i` flips in the middle of a frame.
- **Pending requests:** requests raised during a frame must yield exactly one further frame, with the exact hold gap. A reader that drops or duplicates them would show a missing frame or an extra one.
- **Power-up hold-off:** a start request issued in the first cycle after reset must be delayed by the hold-off, and then served exactly once.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_HOLD
  } rd_state_e;

  typedef enum logic {
    FRM_BYTE  = 1'b0,
    FRM_SHORT = 1'b1
  } frame_mode_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_req.sv
module adc_rd_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic accept_i,
  output logic go_o
);
  logic pend_q;

  assign go_o = start_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (accept_i) pend_q <= 1'b0;
    else if (start_i)  pend_q <= 1'b1;
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned HALF_DIV    = 26,
  parameter int unsigned SETUP_CYC   = 12,
  parameter int unsigned CS_HOLD_CYC = 52,
  parameter int unsigned POWERUP_CYC = 625000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic mode_i,
  output logic cs_no,
  output logic sclk_o,
  output logic sample_o,
  output logic done_o,
  output logic accept_o
);
  localparam int unsigned CNT_MAX    = umax(umax(POWERUP_CYC, SETUP_CYC), umax(HALF_DIV, CS_HOLD_CYC));
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
  localparam int unsigned BYTE_CLKS  = DATA_W + 4;
  localparam int unsigned SHORT_CLKS = DATA_W + 3;
  localparam int unsigned EDGE_W     = $clog2(BYTE_CLKS + 1);

  rd_state_e         state_q;
  frame_mode_e       mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic              cs_nq, sclk_q;
  logic              cnt_zero, last_clk, is_byte;

  assign cnt_zero = (cnt_q == '0);
  assign is_byte  = (mode_q == FRM_BYTE);
  assign last_clk = is_byte ? (edge_q == EDGE_W'(BYTE_CLKS)) : (edge_q == EDGE_W'(SHORT_CLKS));

  // byte framing samples ahead of each rise, short framing ahead of each fall
  assign sample_o = cnt_zero & ((state_q == ST_SETUP & is_byte) |
                                (state_q == ST_LO & ~last_clk & is_byte) |
                                (state_q == ST_HI & ~is_byte));
  assign done_o   = cnt_zero & (state_q == ST_LO) & last_clk;
  assign accept_o = (state_q == ST_IDLE) & go_i;
  assign cs_no    = cs_nq;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      mode_q  <= FRM_BYTE;
      cnt_q   <= CNT_W'(POWERUP_CYC - 1);
      edge_q  <= '0;
      cs_nq   <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PWR: begin
          if (cnt_zero) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        ST_IDLE: begin
          if (go_i) begin
            state_q <= ST_SETUP;
            cs_nq   <= 1'b0;
            cnt_q   <= CNT_W'(SETUP_CYC - 1);
            edge_q  <= '0;
            mode_q  <= frame_mode_e'(mode_i);
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_HI;
            sclk_q  <= 1'b1;
            cnt_q   <= CNT_W'(HALF_DIV - 1);
            edge_q  <= edge_q + 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HI: begin
          if (cnt_zero) begin
            state_q <= ST_LO;
            sclk_q  <= 1'b0;
            cnt_q   <= CNT_W'(HALF_DIV - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_LO: begin
          if (cnt_zero) begin
            if (last_clk) begin
              state_q <= ST_HOLD;
              cs_nq   <= 1'b1;
              cnt_q   <= CNT_W'(CS_HOLD_CYC - 1);
            end else begin
              state_q <= ST_HI;
              sclk_q  <= 1'b1;
              cnt_q   <= CNT_W'(HALF_DIV - 1);
              edge_q  <= edge_q + 1'b1;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: begin
          if (cnt_zero) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  // one extra stage holds the trailing sample, which both framings drop
  logic [DATA_W:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (sample_i) sr_q <= {sr_q[DATA_W-1:0], sdi_i};
      if (done_i)   result_o <= sr_q[DATA_W:1];
      valid_o <= done_i;
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int unsigned DATA_W         = 12,
  parameter int unsigned HALF_DIV       = 26,
  parameter int unsigned SETUP_CYC      = 12,
  parameter int unsigned CS_HOLD_HALVES = 2,
  parameter int unsigned POWERUP_CYC    = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int unsigned CS_HOLD_CYC = CS_HOLD_HALVES * HALF_DIV;

  logic go, accept, sample, done;

  adc_rd_req u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_i(accept),
    .go_o    (go)
  );

  adc_rd_seq #(
    .DATA_W     (DATA_W),
    .HALF_DIV   (HALF_DIV),
    .SETUP_CYC  (SETUP_CYC),
    .CS_HOLD_CYC(CS_HOLD_CYC),
    .POWERUP_CYC(POWERUP_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .mode_i  (mode_i),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .sample_o(sample),
    .done_o  (done),
    .accept_o(accept)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .sdi_i   (miso_i),
    .done_i  (done),
    .result_o(result_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned HALF_DIV    = 26,
  parameter int unsigned CS_HOLD_CYC = 52
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_no,
  input logic              sclk_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int unsigned HW = $clog2(HALF_DIV + 2);
  localparam int unsigned CW = $clog2(CS_HOLD_CYC + 1);

  logic [HW-1:0] hi_run_q;
  logic [CW-1:0] cs_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      cs_hi_q  <= CW'(CS_HOLD_CYC);
    end else begin
      if (!sclk_o)                         hi_run_q <= '0;
      else if (hi_run_q != HW'(HALF_DIV + 1)) hi_run_q <= hi_run_q + 1'b1;
      if (!cs_no)                          cs_hi_q <= '0;
      else if (cs_hi_q != CW'(CS_HOLD_CYC)) cs_hi_q <= cs_hi_q + 1'b1;
    end
  end

  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_no |-> !sclk_o); // R3
  AST_CS_FALL_WITH_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(cs_no) |-> !sclk_o); // R3
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(sclk_o) |-> hi_run_q == HW'(HALF_DIV)); // R4
  AST_CS_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(cs_no) |-> cs_hi_q == CW'(CS_HOLD_CYC)); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |=> !valid_o); // R8
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cs_no) |-> valid_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_o |-> $stable(result_o)); // R8
endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .DATA_W     (DATA_W),
  .HALF_DIV   (HALF_DIV),
  .CS_HOLD_CYC(CS_HOLD_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/adc_serial_reader_test.sv
module adc_serial_reader_test;
  localparam int H   = 2;
  localparam int S   = 3;
  localparam int CHH = 2;
  localparam int P   = 40;
  localparam int CSH = CHH * H;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic miso;
  logic cs_no, sclk_o, valid_o;
  logic [11:0] result_o;

  always #2 clk_i = ~clk_i;

  adc_serial_reader #(
    .DATA_W(12), .HALF_DIV(H), .SETUP_CYC(S), .CS_HOLD_HALVES(CHH), .POWERUP_CYC(P)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i), .miso_i(miso),
    .cs_no(cs_no), .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o)
  );

  // converter model: each rising sclk edge launches the next frame bit
  logic [11:0] code_r = '0;
  logic [5:0]  k = '0;
  always @(negedge cs_no or posedge sclk_o) begin
    if (!sclk_o) k <= '0;
    else         k <= k + 6'd1;
  end
  assign miso = (!cs_no && k >= 6'd3 && k <= 6'd14) ? code_r[6'd14 - k] : 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, frames = 0, rises = 0, setup_len = 0, hi_len = 0, lo_len = 0;
  int cs_hi_len = 0, last_cs_hi = 0;
  int hi_bad = 0, lo_bad = 0, idle_bad = 0, valid_bad = 0, res_bad = 0;
  bit in_setup = 0, lo_act = 0, p_cs = 1, p_sclk = 0, p_valid = 0;
  logic [11:0] p_res = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual %0d expected below 190000", cyc);
      finish_run();
    end
    if (rst_ni) begin
      if (!cs_no && p_cs) begin
        frames++; rises = 0; setup_len = 0; in_setup = 1;
        last_cs_hi = cs_hi_len; cs_hi_len = 0;
      end
      if (cs_no) cs_hi_len++;
      if (in_setup) begin
        if (sclk_o) in_setup = 0; else setup_len++;
      end
      if (sclk_o && !p_sclk) begin
        rises++;
        if (lo_act && lo_len != H) lo_bad++;
        lo_act = 0; hi_len = 0;
      end
      if (sclk_o) hi_len++;
      if (!sclk_o && p_sclk) begin
        if (hi_len != H) hi_bad++;
        lo_act = 1; lo_len = 0;
      end
      if (cs_no && !p_cs) begin
        if (lo_act && lo_len != H) lo_bad++;
        lo_act = 0;
      end
      if (lo_act && !sclk_o && !cs_no) lo_len++;
      if (cs_no && sclk_o) idle_bad++;
      if (valid_o && (p_valid || !(cs_no && !p_cs))) valid_bad++;
      if (!valid_o && result_o != p_res) res_bad++;
    end
    p_cs = cs_no; p_sclk = sclk_o; p_valid = valid_o; p_res = result_o;
  end

  task automatic wait_valid(input string tag);
    bit got = 0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk_i);
      if (valid_o) got = 1;
    end
    chk(got, tag, 0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic run_frame(input int code, input bit mode);
    code_r = 12'(code);
    mode_i = mode;
    pulse_start();
    chk(cs_no == 1'b0, "R11 cs falls on start edge", cs_no, 0);
    wait_valid(mode ? "R6 valid" : "R5 valid");
    if (mode) begin
      chk(result_o == 12'(code), "R6 short result", result_o, code);
      chk(rises == 15, "R6 short clock count", rises, 15);
    end else begin
      chk(result_o == 12'(code), "R5 byte result", result_o, code);
      chk(rises == 16, "R5 byte clock count", rises, 16);
    end
    chk(setup_len == S, "R3 setup cycles", setup_len, S);
    repeat (CSH + 2) @(negedge clk_i);
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 reset cs", cs_no, 1);
    chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    chk(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    chk(result_o == 12'd0, "R1 reset result", result_o, 0);

    // R2: request right after reset is held through the power-up wait
    code_r = 12'hA5C;
    mode_i = 1'b0;
    rst_ni = 1'b1;
    start_i = 1'b1;
    begin
      int n = 0;
      bit seen = 0;
      for (int i = 1; i <= P + 20 && !seen; i++) begin
        @(negedge clk_i);
        start_i = 1'b0;
        if (!cs_no) begin seen = 1; n = i; end
      end
      chk(n == P + 1, "R2 power-up hold-off", n, P + 1);
    end
    wait_valid("R2 valid");
    chk(result_o == 12'hA5C, "R2 first result", result_o, 12'hA5C);
    repeat (CSH + 2) @(negedge clk_i);

    // sweep of codes through both framings
    for (int c = 0; c < 4096; c += 7) begin
      run_frame(c, 1'b0);
      run_frame(c, 1'b1);
    end
    run_frame(4095, 1'b0);
    run_frame(4095, 1'b1);
    for (int b = 0; b < 12; b++) run_frame(1 << b, b[0]);

    // R10: flipping the mode mid-frame changes nothing
    code_r = 12'h3C7;
    mode_i = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk_i);
    mode_i = 1'b1;
    wait_valid("R10 valid");
    chk(rises == 16, "R10 clock count after mode flip", rises, 16);
    chk(result_o == 12'h3C7, "R10 result after mode flip", result_o, 12'h3C7);
    repeat (CSH + 2) @(negedge clk_i);

    // R9: requests during a frame merge into one follow-up frame
    f0 = frames;
    code_r = 12'h812;
    mode_i = 1'b0;
    pulse_start();
    repeat (10) @(negedge clk_i);
    pulse_start();
    repeat (5) @(negedge clk_i);
    pulse_start();
    wait_valid("R9 first valid");
    chk(result_o == 12'h812, "R9 first result", result_o, 12'h812);
    code_r = 12'h0F3;
    wait_valid("R9 pending valid");
    chk(result_o == 12'h0F3, "R9 pending result", result_o, 12'h0F3);
    chk(last_cs_hi == CSH + 1, "R7 back-to-back cs high", last_cs_hi, CSH + 1);
    repeat (120) @(negedge clk_i);
    chk(frames == f0 + 2, "R9 merged frame count", frames - f0, 2);

    chk(hi_bad == 0, "R4 high phase length", hi_bad, 0);
    chk(lo_bad == 0, "R4 low phase length", lo_bad, 0);
    chk(idle_bad == 0, "R3 sclk low when deselected", idle_bad, 0);
    chk(valid_bad == 0, "R8 valid pulse placement", valid_bad, 0);
    chk(res_bad == 0, "R8 result stable between strobes", res_bad, 0);
    finish_run();
  end
endmodule